// File: doc/BRIEF.md
# Region Pattern Fill and Verify Sequencer

This block drives a word-wide memory port through a fixed series of seven fill-and-check phases over a memory region. A phase writes its pattern to every word of the current window first. It then reads the window back word by word and compares each word with the value it expects. The run stops at the first word that does not match. The failing byte address, the value expected there and the value read are then held on the outputs.

A run is launched with a one-cycle `start` pulse. The region base, region size and mode are sampled on that pulse. In full mode the whole region is one window. In sparse mode the region is split into blocks of 2^BLOCK_SHIFT bytes. For every complete block, two windows of WIN_BYTES bytes are tested: one at the bottom of the block and one just below the next block boundary. The word index that feeds the index-based patterns restarts at zero in every window.

A keepalive pulse is raised during long runs so that an external timer supervising the run is not starved.

Top module: `mpt_seq_top`

## Requirements
- R1: Within each window the phases run in this order: all zeros, all ones, 0x55555555, 0xAAAAAAAA, walking one (bit number = word index mod DATA_W set), word index, bitwise complement of the word index.
- R2: Each phase issues one unbroken burst of writes covering the window, followed by a separate read pass over the same window. A run of P phases over W windows therefore shows exactly 7·W write bursts.
- R3: On the first read mismatch, `done` and `fail` rise together and the block issues no further memory accesses. `fail_addr`, `fail_exp` and `fail_got` hold the byte address, the expected word and the word read. No later phase or window is written.
- R4: `wd_kick` pulses in every fill or verify cycle whose word index is a multiple of 2^KICK_SHIFT. It also pulses for one cycle after each phase's verify pass.
- R5: In sparse mode, block i (counted from the region base) yields a window at base + i·2^BLOCK_SHIFT and then one at base + (i+1)·2^BLOCK_SHIFT − WIN_BYTES. Blocks are visited in ascending order, and bytes outside these windows are never written.
- R6: In full mode the phases cover every word from the base up to base + size, rounded down to whole words.
- R7: The word index used for the walking-one, index and complemented-index patterns is relative to the start of the current window.
- R8: A sparse run over a region smaller than one block, or a full run over less than one word, ends with `done` high, `fail` low and no memory access.
- R9: `done` and the failure record hold until the next `start`, which clears `done` and `fail` and re-samples the base, size and mode.
- R10: At most one access is made per cycle. `mem_we` is only high with `mem_req`. Addresses are word aligned. Read data is taken on `mem_rdata` in the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that launches a run |
| mode_sparse | input | 1 | 1: block-boundary windows, 0: whole region |
| region_base | input | ADDR_W | Byte address of the region start |
| region_size | input | ADDR_W | Region length in bytes |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read request |
| wd_kick | output | 1 | Keepalive pulse |
| done | output | 1 | Run finished |
| fail | output | 1 | Run ended on a mismatch |
| fail_addr | output | ADDR_W | Byte address of the first mismatch |
| fail_exp | output | DATA_W | Value expected at that address |
| fail_got | output | DATA_W | Value read at that address |

## Verification
The bound checker watches the port protocol on every cycle:
- a write is never made without a request, and addresses stay word aligned;
- the block stays silent once `done` is up, and `fail` never appears without `done`;
- the completion state and the failure record hold until the next start;
- a keepalive pulse comes with the first write of every fill burst.

The phase order, the placement of the sparse windows, the per-window restart of the index, the exact keepalive count and the abort point after an injected stuck bit are properties of whole runs. Only the bench scenarios show them, by sweeping the memory image and counting bursts and pulses against values computed from the region geometry.

// File: rtl/mpt_pkg.sv
package mpt_pkg;

   typedef enum logic [2:0] {
      PH_ZERO  = 3'd0,
      PH_ONES  = 3'd1,
      PH_ODD   = 3'd2,
      PH_EVEN  = 3'd3,
      PH_WALK  = 3'd4,
      PH_INDEX = 3'd5,
      PH_INV   = 3'd6
   } phase_e;

   localparam phase_e PH_LAST = PH_INV;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SETUP = 3'd1,
      ST_FILL  = 3'd2,
      ST_READ  = 3'd3,
      ST_DRAIN = 3'd4,
      ST_GAP   = 3'd5,
      ST_DONE  = 3'd6
   } state_e;

endpackage

// File: rtl/mpt_pattern_gen.sv
module mpt_pattern_gen
   import mpt_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  phase_e              phase,
   input  logic [ADDR_W-1:0]   idx,
   output logic [DATA_W-1:0]   pattern
);
   localparam int BIT_SEL_W = $clog2(DATA_W);

   logic [DATA_W-1:0] idx_ext;
   logic [DATA_W-1:0] walk;

   generate
      if (ADDR_W >= DATA_W) begin : g_idx_trunc
         assign idx_ext = idx[DATA_W-1:0];
      end else begin : g_idx_zext
         assign idx_ext = {{(DATA_W-ADDR_W){1'b0}}, idx};
      end
   endgenerate

   assign walk = {{(DATA_W-1){1'b0}}, 1'b1} << idx[BIT_SEL_W-1:0];

   always_comb begin
      unique case (phase)
         PH_ZERO:  pattern = '0;
         PH_ONES:  pattern = '1;
         PH_ODD:   pattern = {(DATA_W/2){2'b01}};
         PH_EVEN:  pattern = {(DATA_W/2){2'b10}};
         PH_WALK:  pattern = walk;
         PH_INDEX: pattern = idx_ext;
         PH_INV:   pattern = ~idx_ext;
         default:  pattern = '0;
      endcase
   end
endmodule

// File: rtl/mpt_window_seq.sv
module mpt_window_seq #(
   parameter int ADDR_W      = 32,
   parameter int BLOCK_SHIFT = 20,
   parameter int WIN_BYTES   = 2048,
   parameter int BYTE_SH     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              sparse,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] size,
   input  logic              advance,
   output logic [ADDR_W-1:0] win_base,
   output logic [ADDR_W-1:0] win_words,
   output logic              win_last,
   output logic              win_none
);
   localparam logic [ADDR_W-1:0] BLOCK_BYTES = ADDR_W'(64'd1 << BLOCK_SHIFT);
   localparam logic [ADDR_W-1:0] HIGH_OFF    = BLOCK_BYTES - ADDR_W'(WIN_BYTES);
   localparam logic [ADDR_W-1:0] WIN_WORDS   = ADDR_W'(WIN_BYTES >> BYTE_SH);

   logic              sparse_q;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W:0]   nwin_q;
   logic [ADDR_W:0]   k_q;
   logic [ADDR_W-1:0] words_q;

   logic [ADDR_W:0]   blk_num;
   logic [ADDR_W-1:0] blk_off;
   logic [ADDR_W-1:0] full_words;

   assign full_words = size >> BYTE_SH;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sparse_q <= 1'b0;
         base_q   <= '0;
         nwin_q   <= '0;
         k_q      <= '0;
         words_q  <= '0;
      end else if (load) begin
         sparse_q <= sparse;
         base_q   <= base;
         k_q      <= '0;
         if (sparse) begin
            nwin_q  <= {1'b0, size >> BLOCK_SHIFT} << 1;
            words_q <= WIN_WORDS;
         end else begin
            nwin_q  <= (full_words != '0) ? (ADDR_W+1)'(1) : '0;
            words_q <= full_words;
         end
      end else if (advance) begin
         k_q <= k_q + 1'b1;
      end
   end

   assign blk_num = k_q >> 1;
   assign blk_off = blk_num[ADDR_W-1:0] << BLOCK_SHIFT;

   always_comb begin
      if (sparse_q) begin
         win_base = base_q + blk_off + (k_q[0] ? HIGH_OFF : '0);
      end else begin
         win_base = base_q;
      end
   end

   assign win_words = words_q;
   assign win_last  = ((k_q + 1'b1) == nwin_q);
   assign win_none  = (nwin_q == '0);
endmodule

// File: rtl/mpt_kick_gen.sv
module mpt_kick_gen #(
   parameter int ADDR_W     = 32,
   parameter int KICK_SHIFT = 10
) (
   input  logic              active,
   input  logic              boundary,
   input  logic [ADDR_W-1:0] idx,
   output logic              kick
);
   logic on_period;

   generate
      if (KICK_SHIFT == 0) begin : g_every
         assign on_period = 1'b1;
      end else begin : g_masked
         assign on_period = (idx[KICK_SHIFT-1:0] == '0);
      end
   endgenerate

   assign kick = (active && on_period) || boundary;
endmodule

// File: rtl/mpt_seq_top.sv
module mpt_seq_top
   import mpt_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int BLOCK_SHIFT = 20,
   parameter int WIN_BYTES   = 2048,
   parameter int KICK_SHIFT  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mode_sparse,
   input  logic [ADDR_W-1:0] region_base,
   input  logic [ADDR_W-1:0] region_size,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              wd_kick,
   output logic              done,
   output logic              fail,
   output logic [ADDR_W-1:0] fail_addr,
   output logic [DATA_W-1:0] fail_exp,
   output logic [DATA_W-1:0] fail_got
);
   localparam int WORD_BYTES = DATA_W / 8;
   localparam int BYTE_SH    = $clog2(WORD_BYTES);

   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
         $error("DATA_W must be a power of two of at least 8");
      end
      if (WIN_BYTES < WORD_BYTES || (WIN_BYTES % WORD_BYTES) != 0) begin : g_bad_win
         $error("WIN_BYTES must be a whole number of words");
      end
      if (BLOCK_SHIFT >= ADDR_W || (2 * WIN_BYTES) > (64'd1 << BLOCK_SHIFT)) begin : g_bad_block
         $error("two windows must fit inside one block");
      end
      if (KICK_SHIFT >= ADDR_W) begin : g_bad_kick
         $error("KICK_SHIFT must be below ADDR_W");
      end
   endgenerate

   state_e            st_q;
   phase_e            phase_q;
   logic [ADDR_W-1:0] idx_q;
   logic              pend_vld_q;
   logic [ADDR_W-1:0] pend_addr_q;
   logic [DATA_W-1:0] pend_exp_q;

   logic              win_load;
   logic              win_adv;
   logic [ADDR_W-1:0] win_base;
   logic [ADDR_W-1:0] win_words;
   logic              win_last;
   logic              win_none;
   logic [ADDR_W-1:0] idx_last;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] cur_pat;
   logic              mismatch;
   logic              idle_like;

   assign idle_like = (st_q == ST_IDLE) || (st_q == ST_DONE);
   assign win_load  = idle_like && start;
   assign win_adv   = (st_q == ST_GAP) && (phase_q == PH_LAST) && !win_last;
   assign idx_last  = win_words - 1'b1;
   assign cur_addr  = win_base + (idx_q << BYTE_SH);
   assign mismatch  = pend_vld_q && (mem_rdata != pend_exp_q);

   mpt_window_seq #(
      .ADDR_W      (ADDR_W),
      .BLOCK_SHIFT (BLOCK_SHIFT),
      .WIN_BYTES   (WIN_BYTES),
      .BYTE_SH     (BYTE_SH)
   ) win_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (win_load),
      .sparse    (mode_sparse),
      .base      (region_base),
      .size      (region_size),
      .advance   (win_adv),
      .win_base  (win_base),
      .win_words (win_words),
      .win_last  (win_last),
      .win_none  (win_none)
   );

   mpt_pattern_gen #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) pat_i (
      .phase   (phase_q),
      .idx     (idx_q),
      .pattern (cur_pat)
   );

   mpt_kick_gen #(
      .ADDR_W     (ADDR_W),
      .KICK_SHIFT (KICK_SHIFT)
   ) kick_i (
      .active   ((st_q == ST_FILL) || (st_q == ST_READ)),
      .boundary (st_q == ST_GAP),
      .idx      (idx_q),
      .kick     (wd_kick)
   );

   always_comb begin
      mem_req   = (st_q == ST_FILL) || (st_q == ST_READ);
      mem_we    = (st_q == ST_FILL);
      mem_addr  = mem_req ? cur_addr : '0;
      mem_wdata = mem_we ? cur_pat : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         phase_q     <= PH_ZERO;
         idx_q       <= '0;
         pend_vld_q  <= 1'b0;
         pend_addr_q <= '0;
         pend_exp_q  <= '0;
         done        <= 1'b0;
         fail        <= 1'b0;
         fail_addr   <= '0;
         fail_exp    <= '0;
         fail_got    <= '0;
      end else begin
         pend_vld_q <= 1'b0;
         unique case (st_q)
            ST_IDLE, ST_DONE: begin
               if (start) begin
                  st_q <= ST_SETUP;
                  done <= 1'b0;
                  fail <= 1'b0;
               end
            end
            ST_SETUP: begin
               idx_q   <= '0;
               phase_q <= PH_ZERO;
               if (win_none) begin
                  st_q <= ST_DONE;
                  done <= 1'b1;
               end else begin
                  st_q <= ST_FILL;
               end
            end
            ST_FILL: begin
               if (idx_q == idx_last) begin
                  idx_q <= '0;
                  st_q  <= ST_READ;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            ST_READ: begin
               pend_vld_q  <= 1'b1;
               pend_addr_q <= cur_addr;
               pend_exp_q  <= cur_pat;
               if (idx_q == idx_last) begin
                  idx_q <= '0;
                  st_q  <= ST_DRAIN;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            ST_DRAIN: begin
               st_q <= ST_GAP;
            end
            ST_GAP: begin
               idx_q <= '0;
               if (phase_q != PH_LAST) begin
                  phase_q <= phase_e'(phase_q + 3'd1);
                  st_q    <= ST_FILL;
               end else if (win_last) begin
                  st_q <= ST_DONE;
                  done <= 1'b1;
               end else begin
                  phase_q <= PH_ZERO;
                  st_q    <= ST_FILL;
               end
            end
            default: st_q <= ST_IDLE;
         endcase

         if (mismatch) begin
            st_q       <= ST_DONE;
            done       <= 1'b1;
            fail       <= 1'b1;
            fail_addr  <= pend_addr_q;
            fail_exp   <= pend_exp_q;
            fail_got   <= mem_rdata;
            pend_vld_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/mpt_seq_chk.sv
module mpt_seq_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              wd_kick,
   input logic              done,
   input logic              fail,
   input logic [ADDR_W-1:0] fail_addr,
   input logic [DATA_W-1:0] fail_exp,
   input logic [DATA_W-1:0] fail_got
);
   localparam int WORD_BYTES = DATA_W / 8;

   AST_WE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_req); // R10

   AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ((mem_addr % WORD_BYTES) == 0)); // R10

   AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req); // R3

   AST_FAIL_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> done); // R3

   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done); // R9

   AST_RECORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> ($stable(fail) && $stable(fail_addr)
                            && $stable(fail_exp) && $stable(fail_got))); // R9

   AST_KICK_AT_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we) |-> wd_kick); // R4
endmodule

bind mpt_seq_top mpt_seq_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .wd_kick   (wd_kick),
   .done      (done),
   .fail      (fail),
   .fail_addr (fail_addr),
   .fail_exp  (fail_exp),
   .fail_got  (fail_got)
);

// File: tb/mpt_seq_top_tb_top.sv
module mpt_seq_top_tb_top;
   localparam int ADDR_W      = 32;
   localparam int DATA_W      = 32;
   localparam int BLOCK_SHIFT = 8;
   localparam int WIN_BYTES   = 32;
   localparam int KICK_SHIFT  = 2;
   localparam int MEM_WORDS   = 256;
   localparam logic [31:0] BASE = 32'h0000_1000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              mode_sparse = 1'b0;
   logic [ADDR_W-1:0] region_base = '0;
   logic [ADDR_W-1:0] region_size = '0;
   logic              mem_req, mem_we, wd_kick, done, fail;
   logic [ADDR_W-1:0] mem_addr, fail_addr;
   logic [DATA_W-1:0] mem_wdata, fail_exp, fail_got;
   logic [DATA_W-1:0] mem_rdata = '0;

   always #4 clk = ~clk;

   mpt_seq_top #(
      .ADDR_W (ADDR_W), .DATA_W (DATA_W), .BLOCK_SHIFT (BLOCK_SHIFT),
      .WIN_BYTES (WIN_BYTES), .KICK_SHIFT (KICK_SHIFT)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .start (start), .mode_sparse (mode_sparse),
      .region_base (region_base), .region_size (region_size),
      .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
      .mem_wdata (mem_wdata), .mem_rdata (mem_rdata), .wd_kick (wd_kick),
      .done (done), .fail (fail), .fail_addr (fail_addr),
      .fail_exp (fail_exp), .fail_got (fail_got)
   );

   logic [DATA_W-1:0] mem [MEM_WORDS];
   bit  fault_en = 0;
   int  fault_word = 0;
   logic [DATA_W-1:0] fault_set = '0, fault_clr = '0;
   int  n_checks = 0, n_errors = 0;
   int  wr_cnt = 0, kick_cnt = 0, burst_cnt = 0, probe_cnt = 0;
   bit  prev_we = 0;
   logic [DATA_W-1:0] probe [8];

   always @(posedge clk) begin
      if (mem_req) begin
         int w;
         w = int'((mem_addr - BASE) >> 2);
         if (w >= 0 && w < MEM_WORDS) begin
            if (mem_we) begin
               mem[w] <= mem_wdata;
               if (w == 5 && probe_cnt < 8) begin
                  probe[probe_cnt] = mem_wdata;
                  probe_cnt++;
               end
            end else if (fault_en && w == fault_word) begin
               mem_rdata <= (mem[w] | fault_set) & ~fault_clr;
            end else begin
               mem_rdata <= mem[w];
            end
         end
      end
      if (mem_req && mem_we) wr_cnt++;
      if (wd_kick) kick_cnt++;
      if (mem_we && !prev_we) burst_cnt++;
      prev_we = mem_we;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic preload();
      for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
   endtask

   task automatic run(input bit sparse, input logic [31:0] size);
      int cyc;
      @(negedge clk);
      wr_cnt = 0; kick_cnt = 0; burst_cnt = 0; probe_cnt = 0;
      mode_sparse = sparse; region_base = BASE; region_size = size;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (!done && cyc < 20000) begin
         @(negedge clk);
         cyc++;
      end
      chk(done, "watchdog", 32'(cyc), 32'd20000);
   endtask

   initial begin
      preload();
      repeat (3) @(negedge clk);
      chk(!done && !fail && !mem_req && !wd_kick, "R9 reset state",
          {28'd0, done, fail, mem_req, wd_kick}, 32'd0);
      rst_n = 1'b1;

      // Full mode, 128 words, clean memory
      run(1'b0, 32'd512);
      chk(!fail, "R6 full pass", 32'(fail), 32'd0);
      chk(wr_cnt == 7*128, "R6 write count", 32'(wr_cnt), 32'd896);
      chk(burst_cnt == 7, "R2 write bursts", 32'(burst_cnt), 32'd7);
      chk(kick_cnt == 7*65, "R4 kick count full", 32'(kick_cnt), 32'd455);
      chk(probe[0] == 32'h0, "R1 phase zero", probe[0], 32'h0);
      chk(probe[1] == 32'hFFFF_FFFF, "R1 phase ones", probe[1], 32'hFFFF_FFFF);
      chk(probe[2] == 32'h5555_5555, "R1 phase 55", probe[2], 32'h5555_5555);
      chk(probe[3] == 32'hAAAA_AAAA, "R1 phase AA", probe[3], 32'hAAAA_AAAA);
      chk(probe[4] == 32'h20, "R1 walking one", probe[4], 32'h20);
      chk(probe[5] == 32'd5, "R1 index", probe[5], 32'd5);
      chk(probe[6] == ~32'd5, "R1 inverted index", probe[6], ~32'd5);
      for (int w = 0; w < MEM_WORDS; w++) begin
         logic [31:0] e;
         e = (w < 128) ? ~32'(w) : (32'hDEAD_0000 | 32'(w));
         if (mem[w] !== e) chk(1'b0, "R6 image", mem[w], e);
      end
      chk(1'b1, "R6 image sweep", 32'd0, 32'd0);

      // Sparse mode, 4 blocks of 64 words, windows of 8 words
      preload();
      run(1'b1, 32'd1024);
      chk(!fail, "R5 sparse pass", 32'(fail), 32'd0);
      chk(wr_cnt == 8*7*8, "R5 write count", 32'(wr_cnt), 32'd448);
      chk(burst_cnt == 56, "R2 sparse bursts", 32'(burst_cnt), 32'd56);
      chk(kick_cnt == 8*7*5, "R4 kick count sparse", 32'(kick_cnt), 32'd280);
      for (int w = 0; w < MEM_WORDS; w++) begin
         int off;
         logic [31:0] e;
         off = w % 64;
         if (off < 8) e = ~32'(off);
         else if (off >= 56) e = ~32'(off - 56);
         else e = 32'hDEAD_0000 | 32'(w);
         if (mem[w] !== e) chk(1'b0, "R7 R5 window image", mem[w], e);
      end
      chk(1'b1, "R7 window image sweep", 32'd0, 32'd0);

      // Sparse mode below one block
      preload();
      run(1'b1, 32'd200);
      chk(!fail && wr_cnt == 0 && kick_cnt == 0, "R8 small sparse",
          32'(wr_cnt + kick_cnt), 32'd0);

      // Stuck-at-0 bit 3 on word 40, full mode
      preload();
      fault_en = 1; fault_word = 40; fault_set = '0; fault_clr = 32'h8;
      run(1'b0, 32'd512);
      chk(fail, "R3 fail flag", 32'(fail), 32'd1);
      chk(fail_addr == BASE + 32'd160, "R3 fail addr", fail_addr, BASE + 32'd160);
      chk(fail_exp == 32'hFFFF_FFFF, "R3 fail exp", fail_exp, 32'hFFFF_FFFF);
      chk(fail_got == 32'hFFFF_FFF7, "R3 fail got", fail_got, 32'hFFFF_FFF7);
      chk(wr_cnt == 256, "R3 no later phase", 32'(wr_cnt), 32'd256);
      chk(kick_cnt == 108, "R4 kick count abort", 32'(kick_cnt), 32'd108);
      chk(mem[127] == 32'hFFFF_FFFF, "R3 image after abort", mem[127], 32'hFFFF_FFFF);
      repeat (5) @(negedge clk);
      chk(done && fail && !mem_req, "R9 hold after fail", {30'd0, done, fail}, 32'd3);

      // Stuck-at-1 bit 0 in the upper window of block 2, sparse mode
      preload();
      fault_word = 187; fault_set = 32'h1; fault_clr = '0;
      run(1'b1, 32'd1024);
      chk(fail_addr == BASE + 32'd748, "R5 sparse fail addr", fail_addr, BASE + 32'd748);
      chk(fail_exp == 32'h0 && fail_got == 32'h1, "R3 sparse fail data", fail_got, 32'h1);
      chk(wr_cnt == 288, "R3 no later window", 32'(wr_cnt), 32'd288);

      // Restart without the fault: start clears the record
      fault_en = 0;
      run(1'b0, 32'd64);
      chk(done && !fail, "R9 restart clears fail", 32'(fail), 32'd0);
      chk(wr_cnt == 7*16, "R9 new size sampled", 32'(wr_cnt), 32'd112);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule